// File: doc/BRIEF.md
# Per-Page Line Rotation Wear Leveler

This block spreads write wear evenly over the physical lines of a page frame in a memory whose cells tolerate a limited number of writes. Each resident page is given a rotation amount, drawn at random when the page is installed in a frame. That amount stays fixed while the page is resident. Every line access to the frame is mapped by adding the amount to the logical line index, modulo the number of lines in a page. Over many page residencies, the writes that land on hot logical lines are scattered across all physical positions.

Install requests arrive on a single valid/ready port and carry an operation code and a frame index. An allocate fills an empty frame. A replace evicts the page in an occupied frame and installs a new one, which receives a freshly drawn amount. A small controller with two states handles each request. In IDLE it holds ready high and accepts a request. It then moves to GRANT for one cycle, reports whether the request was granted or refused, and returns to IDLE. There are two combinational translation paths. The forward path maps a logical line to its physical line. The inverse path maps a physical line back to its logical line, which is used to address write-backs.

Top module: `wl_line_rotator`

## Requirements
- R1: While reset is asserted and right after it, every frame is non-resident, `req_ready` is 1 and `req_done` is 0.
- R2: The random source is a 16-bit register. It loads 0xACE1 in reset. After reset it shifts left every cycle, and the XOR of its bits 15, 13, 12 and 10 enters bit 0. It is never zero.
- R3: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `req_op`=0 is allocate and `req_op`=1 is replace. An allocate to a non-resident frame is granted. The frame becomes resident, and its amount is the low 4 bits of the random state in the accepting cycle.
- R4: In the cycle after an acceptance, `req_done` is 1 and `req_ready` is 0, and the result appears on `req_ok` (1 = granted). In the cycle after that, `req_ready` is 1 again and `req_done` is 0.
- R5: An allocate to a resident frame is refused (`req_ok`=0), and that frame's amount is unchanged.
- R6: A replace to a resident frame is granted. The frame gets a new amount, taken from the low 4 bits of the random state in the accepting cycle.
- R7: A replace to a non-resident frame is refused, and the frame stays non-resident.
- R8: `xl_phys` = (`xl_line` + amount of `xl_frame`) mod 16, and `xl_hit` is the residency of `xl_frame`. A granted install is seen by a translation in the cycle after acceptance.
- R9: `wb_line` = (`wb_phys` − amount of `wb_frame`) mod 16. It is the exact inverse of the forward mapping.
- R10: A frame's amount does not change while requests are made to other frames, or while no request is accepted.
- R11: A frame that is not resident translates as identity: `xl_phys` = `xl_line` and `xl_hit` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Install request present |
| req_op | input | 1 | 0 = allocate, 1 = replace |
| req_frame | input | FRAME_W | Target frame of the request |
| req_ready | output | 1 | Controller is in IDLE and can accept |
| req_done | output | 1 | Result of the last accepted request is valid |
| req_ok | output | 1 | 1 = granted, 0 = refused |
| xl_frame | input | FRAME_W | Frame for forward translation |
| xl_line | input | LINE_W | Logical line index |
| xl_phys | output | LINE_W | Physical line index |
| xl_hit | output | 1 | Frame is resident |
| wb_frame | input | FRAME_W | Frame for inverse translation |
| wb_phys | input | LINE_W | Physical line index |
| wb_line | output | LINE_W | Logical line index |

## Verification
The bench uses the defaults: 8 frames, 16 lines per page and seed 0xACE1. With only eight frames, a few hundred random requests keep landing on frames that are already resident or still empty. Both refusal paths and repeated redraws on the same frame therefore occur many times. With 16 lines, every frame can be swept through all its line indices in both directions after each request. This confirms the modular wrap and the inverse at every amount the random source produces.

// File: rtl/wl_rot_pkg.sv
`timescale 1ns/1ps
package wl_rot_pkg;
    typedef enum logic {
        OP_ALLOC   = 1'b0,
        OP_REPLACE = 1'b1
    } wl_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } wl_state_e;

    localparam int unsigned RNG_W    = 16;
    localparam logic [RNG_W-1:0] RNG_TAPS = 16'hB400;
endpackage

// File: rtl/wl_rng.sv
`timescale 1ns/1ps
module wl_rng
    import wl_rot_pkg::*;
#(
    parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RNG_W-1:0] state
);
    logic [RNG_W-1:0] state_q;
    logic             feedback;

    assign feedback = ^(state_q & RNG_TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= {state_q[RNG_W-2:0], feedback};
        end
    end

    assign state = state_q;
endmodule

// File: rtl/wl_shift_table.sv
`timescale 1ns/1ps
module wl_shift_table #(
    parameter int unsigned FRAMES  = 8,
    parameter int unsigned LINE_W  = 4,
    parameter int unsigned FRAME_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [FRAME_W-1:0]       wr_frame,
    input  logic [LINE_W-1:0]        wr_shift,
    input  logic [FRAME_W-1:0]       req_frame,
    output logic                     req_res,
    input  logic [FRAME_W-1:0]       fw_frame,
    output logic [LINE_W-1:0]        fw_shift,
    output logic                     fw_res,
    input  logic [FRAME_W-1:0]       bw_frame,
    output logic [LINE_W-1:0]        bw_shift,
    output logic [FRAMES-1:0]        res_vec,
    output logic [FRAMES*LINE_W-1:0] shift_flat
);
    logic [LINE_W-1:0] shift_q [FRAMES];
    logic              res_q   [FRAMES];

    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        logic hit_wr;
        assign hit_wr = wr_en && (wr_frame == FRAME_W'(f));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shift_q[f] <= '0;
                res_q[f]   <= 1'b0;
            end else if (hit_wr) begin
                shift_q[f] <= wr_shift;
                res_q[f]   <= 1'b1;
            end
        end

        assign res_vec[f]                       = res_q[f];
        assign shift_flat[f*LINE_W +: LINE_W]   = shift_q[f];
    end

    assign req_res  = res_q[req_frame];
    assign fw_shift = shift_q[fw_frame];
    assign fw_res   = res_q[fw_frame];
    assign bw_shift = shift_q[bw_frame];
endmodule

// File: rtl/wl_rot_unit.sv
`timescale 1ns/1ps
module wl_rot_unit #(
    parameter int unsigned LINE_W  = 4,
    parameter bit          INVERSE = 1'b0
) (
    input  logic [LINE_W-1:0] idx_in,
    input  logic [LINE_W-1:0] amount,
    output logic [LINE_W-1:0] idx_out
);
    if (INVERSE) begin : g_back
        assign idx_out = idx_in - amount;
    end else begin : g_fwd
        assign idx_out = idx_in + amount;
    end
endmodule

// File: rtl/wl_ctrl.sv
`timescale 1ns/1ps
module wl_ctrl
    import wl_rot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_op,
    input  logic frame_res,
    output logic req_ready,
    output logic accept,
    output logic grant,
    output logic req_done,
    output logic req_ok
);
    wl_state_e state_q, state_d;
    wl_op_e    op;
    logic      ok_q;

    assign op = wl_op_e'(req_op);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ok_q <= grant;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        req_done  = 1'b0;
        req_ok    = 1'b0;
        accept    = 1'b0;
        grant     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept  = 1'b1;
                    grant   = (op == OP_ALLOC) ? !frame_res : frame_res;
                    state_d = ST_GRANT;
                end
            end
            ST_GRANT: begin
                req_done = 1'b1;
                req_ok   = ok_q;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/wl_line_rotator.sv
`timescale 1ns/1ps
module wl_line_rotator
    import wl_rot_pkg::*;
#(
    parameter int unsigned      FRAMES = 8,
    parameter int unsigned      LINES  = 16,
    parameter logic [RNG_W-1:0] SEED   = 16'hACE1,
    localparam int unsigned     FRAME_W = $clog2(FRAMES),
    localparam int unsigned     LINE_W  = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_op,
    input  logic [FRAME_W-1:0] req_frame,
    output logic               req_ready,
    output logic               req_done,
    output logic               req_ok,
    input  logic [FRAME_W-1:0] xl_frame,
    input  logic [LINE_W-1:0]  xl_line,
    output logic [LINE_W-1:0]  xl_phys,
    output logic               xl_hit,
    input  logic [FRAME_W-1:0] wb_frame,
    input  logic [LINE_W-1:0]  wb_phys,
    output logic [LINE_W-1:0]  wb_line
);
    logic [RNG_W-1:0]         rng_state;
    logic                     frame_res;
    logic                     accept;
    logic                     grant;
    logic [LINE_W-1:0]        fw_shift;
    logic [LINE_W-1:0]        bw_shift;
    logic [FRAMES-1:0]        res_vec;
    logic [FRAMES*LINE_W-1:0] shift_flat;

    wl_rng #(.SEED(SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rng_state)
    );

    wl_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .frame_res (frame_res),
        .req_ready (req_ready),
        .accept    (accept),
        .grant     (grant),
        .req_done  (req_done),
        .req_ok    (req_ok)
    );

    wl_shift_table #(
        .FRAMES  (FRAMES),
        .LINE_W  (LINE_W),
        .FRAME_W (FRAME_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (grant),
        .wr_frame   (req_frame),
        .wr_shift   (rng_state[LINE_W-1:0]),
        .req_frame  (req_frame),
        .req_res    (frame_res),
        .fw_frame   (xl_frame),
        .fw_shift   (fw_shift),
        .fw_res     (xl_hit),
        .bw_frame   (wb_frame),
        .bw_shift   (bw_shift),
        .res_vec    (res_vec),
        .shift_flat (shift_flat)
    );

    wl_rot_unit #(.LINE_W(LINE_W), .INVERSE(1'b0)) u_fwd (
        .idx_in  (xl_line),
        .amount  (fw_shift),
        .idx_out (xl_phys)
    );

    wl_rot_unit #(.LINE_W(LINE_W), .INVERSE(1'b1)) u_back (
        .idx_in  (wb_phys),
        .amount  (bw_shift),
        .idx_out (wb_line)
    );
endmodule

// File: rtl/wl_rot_checker.sv
`timescale 1ns/1ps
module wl_rot_checker #(
    parameter int unsigned FRAMES  = 8,
    parameter int unsigned LINE_W  = 4,
    parameter int unsigned FRAME_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     req_done,
    input logic                     req_ok,
    input logic [15:0]              rng_state,
    input logic [FRAMES-1:0]        res_vec,
    input logic [FRAMES*LINE_W-1:0] shift_flat,
    input logic [FRAME_W-1:0]       xl_frame,
    input logic [LINE_W-1:0]        xl_line,
    input logic [LINE_W-1:0]        xl_phys,
    input logic                     xl_hit,
    input logic [FRAME_W-1:0]       wb_frame,
    input logic [LINE_W-1:0]        wb_phys,
    input logic [LINE_W-1:0]        wb_line
);
    a_r2_rng_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rng_state != '0);

    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && req_done));

    a_r4_done_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> $past(req_valid && req_ready));

    a_r5_refusal_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && !req_ok) |-> $stable(shift_flat));

    a_r10_idle_table_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(shift_flat));

    a_r3_residency_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (($past(res_vec) & ~res_vec) == '0));

    a_r9_inverse_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
        ((xl_frame == wb_frame) && (wb_phys == xl_phys)) |-> (wb_line == xl_line));

    a_r11_free_identity: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_phys == xl_line));
endmodule

bind wl_line_rotator wl_rot_checker #(
    .FRAMES  (FRAMES),
    .LINE_W  (LINE_W),
    .FRAME_W (FRAME_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_done   (req_done),
    .req_ok     (req_ok),
    .rng_state  (rng_state),
    .res_vec    (res_vec),
    .shift_flat (shift_flat),
    .xl_frame   (xl_frame),
    .xl_line    (xl_line),
    .xl_phys    (xl_phys),
    .xl_hit     (xl_hit),
    .wb_frame   (wb_frame),
    .wb_phys    (wb_phys),
    .wb_line    (wb_line)
);

// File: tb/sim_wl_line_rotator.sv
`timescale 1ns/1ps
module sim_wl_line_rotator;
    localparam int FRAMES = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_op = 1'b0;
    logic [2:0] req_frame = '0;
    logic       req_ready, req_done, req_ok;
    logic [2:0] xl_frame = '0;
    logic [3:0] xl_line = '0;
    logic [3:0] xl_phys;
    logic       xl_hit;
    logic [2:0] wb_frame = '0;
    logic [3:0] wb_phys = '0;
    logic [3:0] wb_line;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [15:0] rng_m;
    logic [3:0]  sh_m  [FRAMES];
    logic        res_m [FRAMES];

    always #2 clk = ~clk;

    wl_line_rotator u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_frame(req_frame),
        .req_ready(req_ready), .req_done(req_done), .req_ok(req_ok),
        .xl_frame(xl_frame), .xl_line(xl_line), .xl_phys(xl_phys), .xl_hit(xl_hit),
        .wb_frame(wb_frame), .wb_phys(wb_phys), .wb_line(wb_line)
    );

    // R2 reference: seed, left shift, feedback of bits 15,13,12,10
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rng_m <= 16'hACE1;
        else        rng_m <= {rng_m[14:0], rng_m[15] ^ rng_m[13] ^ rng_m[12] ^ rng_m[10]};
    end

    function automatic logic [3:0] fwd_exp(logic [3:0] l, logic [3:0] s);
        return l + s;
    endfunction

    function automatic logic [3:0] inv_exp(logic [3:0] p, logic [3:0] s);
        return p - s;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    // Sweep all lines of one frame in both directions (R8, R9, R10, R11)
    task automatic sweep(int fr);
        for (int l = 0; l < 16; l++) begin
            xl_frame = 3'(fr);
            xl_line  = 4'(l);
            wb_frame = 3'(fr);
            wb_phys  = 4'(l);
            #0.1;
            chk("R8 hit", xl_hit, res_m[fr]);
            if (res_m[fr]) begin
                chk("R8/R10 phys", xl_phys, fwd_exp(4'(l), sh_m[fr]));
                chk("R9 inverse", wb_line, inv_exp(4'(l), sh_m[fr]));
            end else begin
                chk("R11 identity", xl_phys, l);
            end
        end
    endtask

    task automatic do_req(int op, int fr);
        logic [3:0] drawn;
        bit         want_ok;
        @(negedge clk);
        chk("R4 ready before", req_ready, 1);
        req_valid = 1'b1;
        req_op    = op[0];
        req_frame = 3'(fr);
        drawn     = rng_m[3:0];
        want_ok   = (op == 0) ? !res_m[fr] : res_m[fr];
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 done", req_done, 1);
        chk("R4 ready low", req_ready, 0);
        if (op == 0) chk(want_ok ? "R3 alloc ok" : "R5 alloc refused", req_ok, want_ok);
        else         chk(want_ok ? "R6 replace ok" : "R7 replace refused", req_ok, want_ok);
        if (want_ok) begin
            sh_m[fr]  = drawn;
            res_m[fr] = 1'b1;
        end
        // R8: new amount visible in the cycle after acceptance
        xl_frame = 3'(fr);
        xl_line  = 4'($urandom_range(0, 15));
        #0.1;
        chk("R2/R3/R6 drawn amount", xl_phys,
            res_m[fr] ? fwd_exp(xl_line, sh_m[fr]) : xl_line);
        chk("R7 residency", xl_hit, res_m[fr]);
        @(negedge clk);
        chk("R4 ready again", req_ready, 1);
        chk("R4 done low", req_done, 0);
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'd2024);
        for (int f = 0; f < FRAMES; f++) begin
            sh_m[f]  = '0;
            res_m[f] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", req_ready, 1);
        chk("R1 done in reset", req_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        for (int f = 0; f < FRAMES; f++) sweep(f);

        // Directed corners
        do_req(1, 2);            // R7 replace free frame
        do_req(0, 0);            // R3 allocate
        do_req(0, 0);            // R5 allocate occupied
        do_req(1, 0);            // R6 redraw
        do_req(0, 7);
        sweep(0);                // R10 frame 0 unchanged by frame 7
        repeat (5) @(negedge clk);
        sweep(7);                // R10 idle cycles

        for (int i = 0; i < 300; i++) begin
            do_req(int'($urandom_range(0, 1)), int'($urandom_range(0, FRAMES - 1)));
            sweep(int'($urandom_range(0, FRAMES - 1)));
        end
        for (int f = 0; f < FRAMES; f++) sweep(f);
        finish_run();
    end
endmodule